// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Sixteenth-Bit Stop Control

This block serialises characters onto an asynchronous line. A clock enable pulses sixteen times per bit period. A character is handed over through a one-entry holding register, with a ready/load handshake. From there it moves into a shift register and leaves the block as a frame:

- a low start bit;
- five to eight data bits, least significant first;
- an optional parity bit;
- a high stop period.

The stop period is programmed in steps of one sixteenth of a bit.

The frame format is captured when a frame begins, so settings may change while a character waits in the holding register. A clear-to-send input can hold back the start of each new frame. Two status outputs tell the surrounding logic when another character may be written and when the line has fallen fully quiet.

Top module: `uart_frac_tx`

## Requirements
- R1: The line idles high. A frame starts with one low bit, followed by the data bits least significant bit first. The start bit and every data bit last exactly 16 enable pulses. The `char_len` code selects the data bit count: 0→5, 1→6, 2→7, 3→8.
- R2: The high stop period lasts `stop_code`+9 pulses for codes 0..7 (9..16 pulses). It lasts `stop_code`+17 pulses for codes 8..15 (25..32 pulses). When a character is waiting, the next start bit follows the stop period with no gap.
- R3: When `char_len` is 0 (5 data bits), codes 0..7 add 8 pulses to the stop period. Codes 8..15 add nothing.
- R4: `par_mode` controls the bit placed after the data bits:
  - 0: a parity bit is present. With `par_type`=0 the total count of ones in the data bits and the parity bit is even; with `par_type`=1 it is odd.
  - 1: a parity bit is present and equals `par_type`.
  - 2: no parity bit is sent.
  - 3: an address/data flag equal to `par_type` is sent (1 = address).
- R5: While `cts_en` is 1 and `cts` is 0, no new frame starts. A waiting character starts once `cts` is 1.
- R6: While `tx_en` is 0, `tx_rdy` is 0 and a pulse on `ld` is ignored: the line stays high and `tx_emt` stays 1.
- R7: `tx_emt` is 1 only when the holding register is empty and no frame, including its stop period, is in progress. It is 1 out of reset.
- R8: `tx_rdy` is 1 when the transmitter is enabled and the holding register is empty. A cycle with `ld` and `tx_rdy` both high stores `ld_data`, and `tx_rdy` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| tx_en | input | 1 | Transmitter enable |
| cts_en | input | 1 | Gate frame starts on `cts` |
| cts | input | 1 | Clear to send, active high |
| ld | input | 1 | Load strobe for the holding register |
| ld_data | input | DATA_W | Character to send |
| char_len | input | 2 | Data bit count code |
| par_mode | input | 2 | Parity mode code |
| par_type | input | 1 | Parity sense, forced value or address flag |
| stop_code | input | 4 | Stop length code |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Holding and shift registers both empty |

## Verification
Back-to-back frames are sent so that the spacing between start edges measures each stop period to the exact pulse. This includes the jump between codes 7 and 8, and the extra half bit added only for five-bit characters. A table with a missed gap, or an added half bit that leaked into the long codes, shifts the next start edge and the bench reports it.

Each parity mode is driven with characters of both even and odd weight. A swapped sense or a forced value that follows the data instead of `par_type` shows up as a wrong bit in the frame.

Loads with clear-to-send withheld, and loads while disabled, are aimed at a design that starts early, accepts a character it should refuse, or reports itself empty while a character still waits.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int UFT_LEN_W  = 4;
  localparam int UFT_STOP_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } uft_state_e;

  // Frame format captured at the start of a frame
  typedef struct packed {
    logic [UFT_LEN_W-1:0]  nbits;
    logic                  par_en;
    logic                  par_bit;
    logic [UFT_STOP_W-1:0] stop_len;
  } uft_fmt_t;

endpackage

// File: rtl/uft_hold.sv
module uft_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              take,
  output logic              hold_full,
  output logic              hold_nxt,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_rdy
);

  logic accept;

  // tx_rdy low means the holding register is full or disabled, so accept and take never coincide
  assign accept   = ld && tx_rdy;
  assign hold_nxt = (hold_full && !take) || accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      tx_rdy    <= 1'b0;
      hold_data <= '0;
    end else begin
      hold_full <= hold_nxt;
      tx_rdy    <= tx_en && !hold_nxt;
      if (accept) hold_data <= ld_data;
    end
  end

endmodule

// File: rtl/uft_fmt.sv
module uft_fmt
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              par_type,
  input  logic [3:0]        stop_code,
  output uft_fmt_t          fmt
);

  localparam int MIN_BITS = 5;
  localparam int HALF     = OVS / 2;

  logic [DATA_W-1:0]     masked;
  logic [UFT_LEN_W-1:0]  nbits;
  logic [UFT_STOP_W-1:0] base_len;

  assign nbits = UFT_LEN_W'(MIN_BITS) + UFT_LEN_W'(char_len);

  // Only the bits that will be sent take part in parity
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] && (UFT_LEN_W'(i) < nbits);
  end

  always_comb begin
    if (stop_code[3]) begin
      base_len = UFT_STOP_W'(OVS + 1) + UFT_STOP_W'(stop_code);
    end else begin
      base_len = UFT_STOP_W'(HALF + 1) + UFT_STOP_W'(stop_code);
      if (char_len == 2'b00) base_len = base_len + UFT_STOP_W'(HALF);
    end
  end

  always_comb begin
    fmt.nbits    = nbits;
    fmt.stop_len = base_len;
    fmt.par_en   = (par_mode != 2'b10);
    fmt.par_bit  = (par_mode == 2'b00) ? ((^masked) ^ par_type) : par_type;
  end

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              tx_en,
  input  logic              cts_en,
  input  logic              cts,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              par_type,
  input  logic [3:0]        stop_code,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_emt
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic                  hold_full, hold_nxt, take, can_start;
  logic [DATA_W-1:0]     hold_data;
  uft_fmt_t              fmt_now, fmt_q, fmt_n;
  uft_state_e            st, st_n;
  logic [UFT_STOP_W-1:0] cnt, cnt_n;
  logic [IDX_W-1:0]      idx, idx_n;
  logic [DATA_W-1:0]     shreg, shreg_n;
  logic                  txd_n;
  logic                  bit_end, stop_end, last_data;

  uft_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .ld        (ld),
    .ld_data   (ld_data),
    .take      (take),
    .hold_full (hold_full),
    .hold_nxt  (hold_nxt),
    .hold_data (hold_data),
    .tx_rdy    (tx_rdy)
  );

  uft_fmt #(.DATA_W(DATA_W), .OVS(OVS)) u_fmt (
    .data      (hold_data),
    .char_len  (char_len),
    .par_mode  (par_mode),
    .par_type  (par_type),
    .stop_code (stop_code),
    .fmt       (fmt_now)
  );

  assign can_start = hold_full && (!cts_en || cts);
  assign bit_end   = (cnt == UFT_STOP_W'(OVS - 1));
  assign stop_end  = (cnt == fmt_q.stop_len - UFT_STOP_W'(1));
  assign last_data = (UFT_LEN_W'(idx) == fmt_q.nbits - UFT_LEN_W'(1));

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    idx_n   = idx;
    shreg_n = shreg;
    txd_n   = txd;
    fmt_n   = fmt_q;
    take    = 1'b0;
    if (tick16) begin
      case (st)
        ST_IDLE: take = can_start;
        ST_START: begin
          if (bit_end) begin
            st_n  = ST_DATA;
            cnt_n = '0;
            idx_n = '0;
            txd_n = shreg[0];
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_n = '0;
            if (last_data) begin
              st_n  = fmt_q.par_en ? ST_PAR : ST_STOP;
              txd_n = fmt_q.par_en ? fmt_q.par_bit : 1'b1;
            end else begin
              idx_n   = idx + 1'b1;
              shreg_n = shreg >> 1;
              txd_n   = shreg[1];
            end
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            st_n  = ST_STOP;
            cnt_n = '0;
            txd_n = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (stop_end) begin
            if (can_start) take = 1'b1;
            else           st_n = ST_IDLE;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
      if (take) begin
        st_n    = ST_START;
        cnt_n   = '0;
        idx_n   = '0;
        txd_n   = 1'b0;
        shreg_n = hold_data;
        fmt_n   = fmt_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      shreg  <= '0;
      txd    <= 1'b1;
      fmt_q  <= '0;
      tx_emt <= 1'b1;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      idx    <= idx_n;
      shreg  <= shreg_n;
      txd    <= txd_n;
      fmt_q  <= fmt_n;
      tx_emt <= (st_n == ST_IDLE) && !hold_nxt;
    end
  end

endmodule

// File: rtl/uft_checker.sv
module uft_checker
  import uft_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       cts_en,
  input logic       cts,
  input logic       ld,
  input logic       txd,
  input logic       tx_rdy,
  input logic       tx_emt,
  input uft_state_e st
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    tx_emt |-> txd);

  assert_rdy_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
    tx_rdy |-> $past(tx_en));

  assert_ignored_load_R6: assert property (@(posedge clk) disable iff (rst)
    (ld && !tx_rdy && tx_emt) |=> tx_emt);

  assert_cts_block_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && cts_en && !cts) |=> txd);

  assert_accept_clears_rdy_R8: assert property (@(posedge clk) disable iff (rst)
    (ld && tx_rdy) |=> (!tx_rdy && !tx_emt));

endmodule

bind uart_frac_tx uft_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .tx_en  (tx_en),
  .cts_en (cts_en),
  .cts    (cts),
  .ld     (ld),
  .txd    (txd),
  .tx_rdy (tx_rdy),
  .tx_emt (tx_emt),
  .st     (st)
);

// File: tb/uart_frac_tx_bench.sv
module uart_frac_tx_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       tx_en = 1'b0;
  logic       cts_en = 1'b0;
  logic       cts = 1'b0;
  logic       ld = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic [1:0] char_len = 2'd3;
  logic [1:0] par_mode = 2'd2;
  logic       par_type = 1'b0;
  logic [3:0] stop_code = 4'd0;
  logic       txd, tx_rdy, tx_emt;

  int total = 0;
  int bad = 0;
  int tick_no = 0;
  int last_start = 0;
  logic [1:0] divc = 2'd0;

  typedef struct {
    logic [15:0] bits;
    int          nb;
    int          stop_len;
    int          gap;
    string       tag;
  } frame_t;

  frame_t exp_q[$];

  always #5 clk = ~clk;

  always @(negedge clk) begin
    divc   <= divc + 2'd1;
    tick16 <= (divc == 2'd3);
  end

  uart_frac_tx u_uart_frac_tx (
    .clk(clk), .rst(rst), .tick16(tick16), .tx_en(tx_en), .cts_en(cts_en),
    .cts(cts), .ld(ld), .ld_data(ld_data), .char_len(char_len),
    .par_mode(par_mode), .par_type(par_type), .stop_code(stop_code),
    .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
  );

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Expected frame from the requirement formulas; returns its length in pulses
  task automatic push_frame(input logic [7:0] d, input int gap, input string tag, output int flen);
    frame_t f;
    int n, ones;
    n = 5 + int'(char_len);
    f.bits = '0;
    ones = 0;
    for (int i = 0; i < n; i++) begin
      f.bits[1+i] = d[i];
      if (d[i]) ones++;
    end
    f.nb = 1 + n;
    if (par_mode != 2'd2) begin
      if (par_mode == 2'd0) f.bits[f.nb] = par_type ? ((ones % 2) == 0) : ((ones % 2) == 1);
      else                  f.bits[f.nb] = par_type;
      f.nb++;
    end
    if (stop_code >= 4'd8) f.stop_len = int'(stop_code) + 17;
    else                   f.stop_len = int'(stop_code) + 9 + ((char_len == 2'd0) ? 8 : 0);
    f.gap = gap;
    f.tag = tag;
    flen = 16 * f.nb + f.stop_len;
    exp_q.push_back(f);
  endtask

  task automatic do_load(input logic [7:0] d);
    int guard = 0;
    @(negedge clk);
    while (!tx_rdy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    ld = 1'b1;
    ld_data = d;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (!(tx_emt && exp_q.size() == 0) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic pair(input logic [7:0] d0, input logic [7:0] d1, input string tag);
    int f0, f1;
    push_frame(d0, 0, tag, f0);
    do_load(d0);
    push_frame(d1, f0, tag, f1);
    do_load(d1);
    wait_idle();
    check(tx_emt == 1'b1 && txd == 1'b1, {tag, "/R7 empty after frames"}, int'(tx_emt), 1);
  endtask

  task automatic next_sample(output logic v, output int idx);
    do @(negedge clk); while (!tick16);
    v = txd;
    idx = tick_no;
    tick_no++;
  endtask

  // Monitor: one sample per enable pulse, compared against the queue
  initial begin
    logic v;
    int s, k;
    frame_t e;
    wait (rst == 1'b0);
    forever begin
      next_sample(v, s);
      if (v == 1'b0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R5 unexpected frame start", s, -1);
          last_start = s;
        end else begin
          logic stop_ok;
          e = exp_q.pop_front();
          if (e.gap != 0)
            check(s - last_start == e.gap, {e.tag, " R2/R3 start spacing"}, s - last_start, e.gap);
          last_start = s;
          stop_ok = 1'b1;
          for (int i = 1; i < 16 * e.nb + e.stop_len; i++) begin
            next_sample(v, k);
            if (i < 16 * e.nb) begin
              if (i % 16 == 8)
                check(v == e.bits[i/16], {e.tag, " R1/R4 frame bit"}, int'(v), int'(e.bits[i/16]));
            end else if (v !== 1'b1) begin
              stop_ok = 1'b0;
            end
          end
          check(stop_ok, {e.tag, " R2 stop period high"}, int'(stop_ok), 1);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(txd == 1'b1, "R1 line high in reset", int'(txd), 1);
    check(tx_emt == 1'b1, "R7 empty in reset", int'(tx_emt), 1);
    check(tx_rdy == 1'b0, "R8 not ready in reset", int'(tx_rdy), 0);
    rst = 1'b0;
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_rdy == 1'b1, "R8 ready when enabled and empty", int'(tx_rdy), 1);

    // 8 bits, no parity, longest stop
    char_len = 2'd3; par_mode = 2'd2; stop_code = 4'hF;
    pair(8'hA5, 8'h3C, "R1 8N code15");
    // 7 bits even parity, shortest stop
    char_len = 2'd2; par_mode = 2'd0; par_type = 1'b0; stop_code = 4'h0;
    pair(8'h55, 8'h07, "R4 7E code0");
    // 5 bits odd parity, half bit added
    char_len = 2'd0; par_mode = 2'd0; par_type = 1'b1; stop_code = 4'h7;
    pair(8'h1F, 8'hE2, "R3 5O code7");
    // 5 bits, long code: no half bit
    char_len = 2'd0; par_mode = 2'd2; stop_code = 4'h8;
    pair(8'h15, 8'h0A, "R3 5N code8");
    // 6 bits forced parity = 1
    char_len = 2'd1; par_mode = 2'd1; par_type = 1'b1; stop_code = 4'h3;
    pair(8'h00, 8'h3F, "R4 forced1");
    // multidrop address then data flag
    char_len = 2'd3; par_mode = 2'd3; par_type = 1'b1; stop_code = 4'h4;
    pair(8'h81, 8'h42, "R4 multidrop addr");
    par_type = 1'b0;
    pair(8'hFF, 8'h01, "R4 multidrop data");
    // 8 bits even, code 10
    char_len = 2'd3; par_mode = 2'd0; par_type = 1'b0; stop_code = 4'hA;
    pair(8'hFF, 8'h80, "R2 8E code10");
    // 6 bits odd, code 1
    char_len = 2'd1; par_mode = 2'd0; par_type = 1'b1; stop_code = 4'h1;
    pair(8'h2A, 8'h11, "R2 6O code1");

    // Clear-to-send gating
    begin
      int fl;
      char_len = 2'd3; par_mode = 2'd2; stop_code = 4'h0;
      cts_en = 1'b1; cts = 1'b0;
      push_frame(8'hC3, 0, "R5 cts release", fl);
      do_load(8'hC3);
      repeat (300) @(negedge clk);
      check(txd == 1'b1, "R5 held by cts", int'(txd), 1);
      check(tx_emt == 1'b0, "R7 not empty while char waits", int'(tx_emt), 0);
      check(tx_rdy == 1'b0, "R8 not ready while holding full", int'(tx_rdy), 0);
      cts = 1'b1;
      wait_idle();
      check(exp_q.size() == 0, "R5 frame sent after cts", exp_q.size(), 0);
      cts_en = 1'b0; cts = 1'b0;
    end

    // Disabled transmitter ignores loads
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_rdy == 1'b0, "R6 not ready when disabled", int'(tx_rdy), 0);
    ld = 1'b1; ld_data = 8'h5A;
    @(negedge clk);
    ld = 1'b0;
    repeat (400) @(negedge clk);
    check(txd == 1'b1, "R6 line stays high", int'(txd), 1);
    check(tx_emt == 1'b1, "R6 stays empty", int'(tx_emt), 1);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_rdy == 1'b1, "R6 ready again when enabled", int'(tx_rdy), 1);
    char_len = 2'd3; par_mode = 2'd2; stop_code = 4'h2;
    pair(8'h69, 8'h96, "R8 after reenable");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule